// File: doc/BRIEF.md
# Signed Sample to Float Converter

This block converts in both directions between N-bit two's-complement sample words and a 32-bit floating-point word. The 32-bit word has a sign in bit 31, an 8-bit exponent in bits 30:23 stored with a bias of 128, and a 23-bit fraction in bits 22:0 behind an implied leading one. A stored exponent E with fraction f therefore means (1.f) times 2 to the power (E - 128). Samples are whole numbers: the binary point sits just right of bit 0.

The block has two independent channels, and each one is a valid/ready stream. The sample-to-float channel takes words from a converter-style source and sends out normalized floats. The float-to-sample channel takes floats and sends out saturated, truncated samples for a converter-style sink.

Each channel has a single output register. An input beat is accepted on a clock edge where in_valid and in_ready are both high. `*_in_ready` is high whenever the output register is empty or its content is being taken in the same cycle. So back-pressure on the output reaches the input within the same cycle, and there is no bubble at full throughput. A result that is waiting for its consumer keeps its value until that consumer accepts it.

Top module: `sample_float_conv`

## Requirements
- R1: A nonzero sample with magnitude M, whose most significant one is at bit p, produces exponent 128+p. The fraction holds the bits of M below bit p, left-aligned in bits 22:0, with zero fill. The sign bit is 0 for a positive sample.
- R2: A sample of zero produces the word 32'h00000000.
- R3: A negative sample is converted from its magnitude and sets bit 31. The most negative sample, -2^(N-1), gives exponent 128+N-1 and a zero fraction.
- R4: A float with 128 <= E < 128+N-1 produces the truncated magnitude floor((1.f) * 2^(E-128)). That magnitude is negated when bit 31 is set.
- R5: A float with E < 128 has magnitude below one and produces sample 0 for either sign.
- R6: A float with E >= 128+N-1 saturates. With bit 31 clear it gives 2^(N-1)-1, and with bit 31 set it gives -2^(N-1).
- R7: An accepted input shows up on its channel's output, with out_valid high, on the clock edge after acceptance. in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, out_valid stays high and the output data holds its value.
- R8: After reset, both out_valid outputs are low and both in_ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s2f_in_valid | input | 1 | Sample input beat present |
| s2f_in_ready | output | 1 | Sample input can be taken |
| s2f_in_data | input | N | Two's-complement sample |
| s2f_out_valid | output | 1 | Float result present |
| s2f_out_ready | input | 1 | Consumer takes float result |
| s2f_out_data | output | 32 | Float result word |
| f2s_in_valid | input | 1 | Float input beat present |
| f2s_in_ready | output | 1 | Float input can be taken |
| f2s_in_data | input | 32 | Float word |
| f2s_out_valid | output | 1 | Sample result present |
| f2s_out_ready | input | 1 | Consumer takes sample result |
| f2s_out_data | output | N | Two's-complement sample result |

## Verification
Every accepted beat is due on its channel's output exactly one edge later. The reference model therefore moves an expected value into a one-entry queue at each acceptance edge and takes it out at each output handshake. At every falling edge, out_valid is compared with whether that queue is occupied, the output data with the head of the queue, and in_ready with the model's own view of the output register and out_ready. Stalls on the output side are driven on purpose, so the model also checks that a held result stays unchanged through every stall cycle.

// File: rtl/sample_float_pkg.sv
package sample_float_pkg;
  localparam int FLT_W    = 32;
  localparam int EXP_W    = 8;
  localparam int FRAC_W   = 23;
  localparam int SIG_W    = FRAC_W + 1;
  localparam int EXP_BIAS = 128;
  localparam int SH_W     = $clog2(SIG_W);

  typedef struct packed {
    logic              sgn;
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
  } flt_word_t;
endpackage

// File: rtl/lead_one_enc.sv
module lead_one_enc #(
  parameter int W  = 16,
  parameter int PW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec,
  output logic [PW-1:0] pos,
  output logic          found
);
  always_comb begin
    pos   = '0;
    found = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) begin
        pos   = PW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/s2f_core.sv
module s2f_core
  import sample_float_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [N-1:0]     smp,
  output logic [FLT_W-1:0] word
);
  localparam int PW = $clog2(N);

  logic [N-1:0]     mag;
  logic [PW-1:0]    lead;
  logic             nz;
  logic [SIG_W-1:0] ext;
  logic [SIG_W-1:0] norm;
  logic [SH_W-1:0]  sh;
  flt_word_t        res;

  assign mag = smp[N-1] ? (~smp + N'(1)) : smp;

  lead_one_enc #(.W(N), .PW(PW)) u_lead (
    .vec  (mag),
    .pos  (lead),
    .found(nz)
  );

  always_comb begin
    ext  = SIG_W'(mag);
    sh   = SH_W'(FRAC_W) - SH_W'(lead);
    norm = ext << sh;
    res.sgn  = smp[N-1];
    res.expo = EXP_W'(EXP_BIAS) + EXP_W'(lead);
    res.frac = norm[FRAC_W-1:0];
    word = nz ? res : '0;
  end
endmodule

// File: rtl/f2s_core.sv
module f2s_core
  import sample_float_pkg::*;
#(
  parameter int N = 16
) (
  input  logic [FLT_W-1:0] word,
  output logic [N-1:0]     smp
);
  flt_word_t        w;
  logic             under;
  logic             sat;
  logic [EXP_W-1:0] k;
  logic [SH_W-1:0]  sh;
  logic [SIG_W-1:0] sig;
  logic [SIG_W-1:0] shifted;
  logic [N-1:0]     mag;

  always_comb begin
    w       = word;
    under   = w.expo < EXP_W'(EXP_BIAS);
    k       = w.expo - EXP_W'(EXP_BIAS);
    sat     = !under && (k >= EXP_W'(N-1));
    sig     = {1'b1, w.frac};
    sh      = SH_W'(FRAC_W) - k[SH_W-1:0];
    shifted = sig >> sh;
    mag     = shifted[N-1:0];
    if (under)
      smp = '0;
    else if (sat)
      smp = w.sgn ? {1'b1, {(N-1){1'b0}}} : {1'b0, {(N-1){1'b1}}};
    else
      smp = w.sgn ? (N'(0) - mag) : mag;
  end
endmodule

// File: rtl/cvt_stage.sv
module cvt_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_drain_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid && out_ready |=> !out_valid);
endmodule

// File: rtl/sample_float_conv.sv
module sample_float_conv
  import sample_float_pkg::*;
#(
  parameter int N = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s2f_in_valid,
  output logic             s2f_in_ready,
  input  logic [N-1:0]     s2f_in_data,
  output logic             s2f_out_valid,
  input  logic             s2f_out_ready,
  output logic [FLT_W-1:0] s2f_out_data,
  input  logic             f2s_in_valid,
  output logic             f2s_in_ready,
  input  logic [FLT_W-1:0] f2s_in_data,
  output logic             f2s_out_valid,
  input  logic             f2s_out_ready,
  output logic [N-1:0]     f2s_out_data
);
  logic [FLT_W-1:0] s2f_word;
  logic [N-1:0]     f2s_smp;

  s2f_core #(.N(N)) u_s2f (.smp(s2f_in_data), .word(s2f_word));
  f2s_core #(.N(N)) u_f2s (.word(f2s_in_data), .smp(f2s_smp));

  cvt_stage #(.W(FLT_W)) u_s2f_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(s2f_in_valid), .in_ready(s2f_in_ready), .in_data(s2f_word),
    .out_valid(s2f_out_valid), .out_ready(s2f_out_ready), .out_data(s2f_out_data)
  );

  cvt_stage #(.W(N)) u_f2s_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(f2s_in_valid), .in_ready(f2s_in_ready), .in_data(f2s_smp),
    .out_valid(f2s_out_valid), .out_ready(f2s_out_ready), .out_data(f2s_out_data)
  );

  logic s2f_acc, f2s_acc;
  assign s2f_acc = s2f_in_valid && s2f_in_ready;
  assign f2s_acc = f2s_in_valid && f2s_in_ready;

  assert_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    s2f_acc && (s2f_in_data == '0) |=> s2f_out_data == '0);

  assert_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
    s2f_acc && (s2f_in_data != '0) |=> s2f_out_data[FLT_W-1] == $past(s2f_in_data[N-1]));

  assert_exp_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    s2f_acc && (s2f_in_data != '0) |=>
      (s2f_out_data[30:23] >= 8'd128) && (s2f_out_data[30:23] <= 8'(128 + N - 1)));

  assert_small_R5: assert property (@(posedge clk) disable iff (!rst_n)
    f2s_acc && (f2s_in_data[30:23] < 8'd128) |=> f2s_out_data == '0);

  assert_sat_pos_R6: assert property (@(posedge clk) disable iff (!rst_n)
    f2s_acc && !f2s_in_data[31] && (f2s_in_data[30:23] >= 8'(128 + N - 1))
      |=> f2s_out_data == {1'b0, {(N-1){1'b1}}});

  assert_sat_neg_R6: assert property (@(posedge clk) disable iff (!rst_n)
    f2s_acc && f2s_in_data[31] && (f2s_in_data[30:23] >= 8'(128 + N - 1))
      |=> f2s_out_data == {1'b1, {(N-1){1'b0}}});
endmodule

// File: tb/test_sample_float_conv.sv
module test_sample_float_conv;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          s_iv = 1'b0, s_or = 1'b0, f_iv = 1'b0, f_or = 1'b0;
  logic [N-1:0]  s_id = '0;
  logic [31:0]   f_id = '0;
  logic          s_ir, s_ov, f_ir, f_ov;
  logic [31:0]   s_od;
  logic [N-1:0]  f_od;

  sample_float_conv #(.N(N)) i_sample_float_conv (
    .clk(clk), .rst_n(rst_n),
    .s2f_in_valid(s_iv), .s2f_in_ready(s_ir), .s2f_in_data(s_id),
    .s2f_out_valid(s_ov), .s2f_out_ready(s_or), .s2f_out_data(s_od),
    .f2s_in_valid(f_iv), .f2s_in_ready(f_ir), .f2s_in_data(f_id),
    .f2s_out_valid(f_ov), .f2s_out_ready(f_or), .f2s_out_data(f_od)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [31:0]  sq[$];
  string        sq_tag[$];
  logic [N-1:0] fq[$];
  string        fq_tag[$];

  function automatic logic [31:0] ref_s2f(logic [N-1:0] v);
    longint val, m;
    int p;
    logic [31:0] fr;
    val = longint'($signed(v));
    if (val == 0) return 32'h0;
    m = (val < 0) ? -val : val;
    p = 0;
    while ((m >> (p + 1)) != 0) p++;
    fr = 32'((m - (longint'(1) << p)) << (23 - p));
    return {(val < 0), 8'(128 + p), fr[22:0]};
  endfunction

  function automatic string tag_s2f(logic [N-1:0] v);
    if (v == '0) return "R2";
    if (v[N-1]) return "R3";
    return "R1";
  endfunction

  function automatic logic [N-1:0] ref_f2s(logic [31:0] w);
    int e, k;
    longint m;
    e = int'(w[30:23]);
    if (e < 128) return '0;
    k = e - 128;
    if (k >= N - 1) return w[31] ? N'(longint'(-(longint'(1) << (N-1)))) : N'((longint'(1) << (N-1)) - 1);
    m = longint'({1'b1, w[22:0]}) >> (23 - k);
    return w[31] ? N'(-m) : N'(m);
  endfunction

  function automatic string tag_f2s(logic [31:0] w);
    if (int'(w[30:23]) < 128) return "R5";
    if (int'(w[30:23]) - 128 >= N - 1) return "R6";
    return "R4";
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  logic [N-1:0] s_dir[$];
  logic [31:0]  f_dir[$];

  initial begin
    s_dir = '{N'(1), N'(0), N'(-1), N'(5), N'(-6), N'((1 << (N-1)) - 1),
              N'(-(1 << (N-1))), N'(1 << (N-2)), N'(3)};
    f_dir = '{32'h40000000, 32'h3F800000, 32'hBFFFFFFF, 32'h40A00000, 32'hC0A00000,
              32'h477FFFFF, 32'hC77FFFFF, 32'h47800000, 32'hC7800000, 32'h4F000000,
              32'h00000000};
  end

  bit s_take = 1, f_take = 1;

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R8: reset state
    check(!s_ov, "R8", "s2f out_valid after reset", s_ov, 0);
    check(!f_ov, "R8", "f2s out_valid after reset", f_ov, 0);
    check(s_ir, "R8", "s2f in_ready after reset", s_ir, 1);
    check(f_ir, "R8", "f2s in_ready after reset", f_ir, 1);
    for (int cyc = 0; cyc < 4000; cyc++) begin
      @(negedge clk);
      if (s_take) begin
        s_iv = (cyc < 20) ? 1'b1 : (cyc < 3900) && ($urandom % 4 != 0);
        if (s_dir.size() > 0) s_id = s_dir.pop_front();
        else s_id = ($urandom % 8 == 0) ? '0 : N'($urandom);
      end
      if (f_take) begin
        f_iv = (cyc < 20) ? 1'b1 : (cyc < 3900) && ($urandom % 3 != 0);
        if (f_dir.size() > 0) f_id = f_dir.pop_front();
        else f_id = {1'($urandom), 8'(118 + $urandom % 40), 23'($urandom)};
      end
      s_or = (cyc < 20) ? 1'b1 : (cyc >= 3900) || ($urandom % 3 != 0);
      f_or = (cyc < 20) ? 1'b1 : (cyc >= 3900) || ($urandom % 4 != 0);
      #1;
      // R7: valid, data and ready of the sample-to-float channel
      check(s_ov == (sq.size() != 0), "R7", "s2f out_valid", s_ov, sq.size() != 0);
      if (s_ov && sq.size() != 0)
        check(s_od == sq[0], sq_tag[0], "s2f out_data", s_od, sq[0]);
      check(s_ir == (sq.size() == 0 || s_or), "R7", "s2f in_ready", s_ir, sq.size() == 0 || s_or);
      check(f_ov == (fq.size() != 0), "R7", "f2s out_valid", f_ov, fq.size() != 0);
      if (f_ov && fq.size() != 0)
        check(f_od == fq[0], fq_tag[0], "f2s out_data", f_od, fq[0]);
      check(f_ir == (fq.size() == 0 || f_or), "R7", "f2s in_ready", f_ir, fq.size() == 0 || f_or);
      s_take = !s_iv || (sq.size() == 0 || s_or);
      f_take = !f_iv || (fq.size() == 0 || f_or);
      if (sq.size() != 0 && s_or) begin void'(sq.pop_front()); void'(sq_tag.pop_front()); end
      if (fq.size() != 0 && f_or) begin void'(fq.pop_front()); void'(fq_tag.pop_front()); end
      if (s_iv && s_take) begin sq.push_back(ref_s2f(s_id)); sq_tag.push_back(tag_s2f(s_id)); end
      if (f_iv && f_take) begin fq.push_back(ref_f2s(f_id)); fq_tag.push_back(tag_f2s(f_id)); end
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule